// File: doc/BRIEF.md
# Selectable-Discipline Flit Forwarding Stage

This block sits on one output path of an on-chip router. It takes flits from an upstream valid/ready port, keeps them in a small local queue, and passes them to the downstream router over a second valid/ready port. A mode input picks one of three ways to grant forwarding. In whole-packet buffering mode (store-and-forward), a packet must be fully resident and fit downstream before it moves. In whole-packet reservation mode (virtual cut-through), the packet moves as soon as the downstream router has room for all of it. In flit-by-flit mode (wormhole), any flit moves when one slot is free downstream.

Free downstream slots are tracked by a credit counter. It starts full. Each flit sent takes one credit, and each pulse on the credit-return input gives one back. The controller is a two-state machine. In `ST_IDLE` it waits for a packet head at the front of the queue and applies the mode rule to it. In `ST_BODY` it streams the rest of an admitted packet one flit per credit, until the tail leaves. The transition `ST_IDLE -> ST_BODY` fires when a multi-flit head is sent. The transition `ST_BODY -> ST_IDLE` fires when a tail is sent. A single-flit packet leaves from `ST_IDLE` and the machine stays in `ST_IDLE`.

Top module: `sw_fwd_stage`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, err_oversize is 0, and the credit count equals DN_DEPTH.
- R2: Kind codes are 00 head, 01 body, 10 tail and 11 single-flit packet. A head carries its packet length L (at least 2) in data bits [LEN_W-1:0], and a single-flit packet has L = 1. Flits leave in arrival order, with kind and data unchanged.
- R3: In mode 00 (store-and-forward), a head is offered only when all L flits of its packet are queued locally and the credit count is at least L.
- R4: In mode 01 (cut-through), a head is offered as soon as the credit count is at least L, even if the rest of the packet has not yet arrived.
- R5: In mode 10 or 11 (wormhole), a flit is offered whenever the credit count is at least 1.
- R6: Once a head has been sent, each following flit of that packet is offered when queued and at least one credit is held. The mode input is ignored until the tail has been sent.
- R7: The credit count drops by one per sent flit and rises by one per credit-return pulse. When both happen in the same cycle it is unchanged. It never exceeds DN_DEPTH, because a return at the maximum is dropped. out_valid is never high with zero credits.
- R8: A store-and-forward head whose L exceeds BUF_DEPTH sets err_oversize, which stays set until reset. That packet is then forwarded as in wormhole mode.
- R9: out_valid does not depend on out_ready. At most one flit leaves per cycle. in_ready is low exactly while BUF_DEPTH flits are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Forwarding discipline: 00 store-and-forward, 01 cut-through, 10/11 wormhole |
| in_valid | input | 1 | Upstream flit present |
| in_ready | output | 1 | Local queue can accept a flit |
| in_kind | input | 2 | Upstream flit kind code |
| in_data | input | DATA_W | Upstream flit payload |
| out_valid | output | 1 | A flit is offered downstream |
| out_ready | input | 1 | Downstream accepts the offered flit |
| out_kind | output | 2 | Offered flit kind code |
| out_data | output | DATA_W | Offered flit payload |
| credit_ret | input | 1 | Downstream freed one slot |
| err_oversize | output | 1 | Sticky flag: store-and-forward packet longer than the local queue |

## Verification
The two functions that can fall in the same cycle are the credit taken by a sent flit and the credit given back by a return pulse. The bench empties the counter in the middle of a wormhole packet. It then holds credit_ret high for two consecutive cycles, so that the second cycle both sends a flit and receives a credit. If the counter keeps its value in that cycle, both remaining flits leave and the stage then stalls with zero credits. An error in either direction changes the count of delivered flits, and the bench compares that count with arithmetic on the credits it has returned.

// File: rtl/sw_fwd_pkg.sv
package sw_fwd_pkg;

    typedef enum logic [1:0] {
        FT_HEAD   = 2'b00,
        FT_BODY   = 2'b01,
        FT_TAIL   = 2'b10,
        FT_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic [1:0] {
        SW_SAF  = 2'b00,
        SW_VCT  = 2'b01,
        SW_WH   = 2'b10,
        SW_WH_B = 2'b11
    } sw_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } fwd_state_e;

endpackage

// File: rtl/flit_buf.sv
module flit_buf #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] front,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign front   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/credit_ctr.sv
module credit_ctr #(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          give,
    output logic [CW-1:0] level
);
    localparam logic [CW-1:0] TOP = CW'(DEPTH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= TOP;
        end else begin
            unique case ({take, give})
                2'b10:   level <= (level != '0) ? level - 1'b1 : level;
                2'b01:   level <= (level != TOP) ? level + 1'b1 : level;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
    import sw_fwd_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int BUF_DEPTH = 4,
    parameter int BCW       = 3,
    parameter int CCW       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             fifo_empty,
    input  logic [1:0]       front_kind,
    input  logic [LEN_W-1:0] front_len,
    input  logic [BCW-1:0]   buf_count,
    input  logic [CCW-1:0]   credits,
    input  logic             out_ready,
    output logic             permit,
    output logic             send,
    output logic             in_body,
    output logic             err_o
);
    fwd_state_e st_q, st_d;
    logic [31:0] need, have_loc, have_crd;
    logic        oversize, head_ok;
    flit_kind_e  kind;

    assign kind     = flit_kind_e'(front_kind);
    assign need     = (kind == FT_HEAD) ? 32'(front_len) : 32'd1;
    assign have_loc = 32'(buf_count);
    assign have_crd = 32'(credits);
    assign oversize = (sw_mode_e'(mode_i) == SW_SAF) && (kind == FT_HEAD)
                      && (need > 32'(BUF_DEPTH));

    // Admission rule for a packet head, chosen by the sampled mode.
    always_comb begin
        unique case (sw_mode_e'(mode_i))
            SW_SAF:  head_ok = oversize ? (have_crd != 0)
                                        : ((have_loc >= need) && (have_crd >= need));
            SW_VCT:  head_ok = (have_crd >= need);
            default: head_ok = (have_crd != 0);
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs and next state.
    always_comb begin
        permit = 1'b0;
        st_d   = st_q;
        unique case (st_q)
            ST_IDLE: begin
                permit = !fifo_empty && head_ok;
                if (permit && out_ready && kind == FT_HEAD) begin
                    st_d = ST_BODY;
                end
            end
            ST_BODY: begin
                permit = !fifo_empty && (have_crd != 0);
                if (permit && out_ready && kind == FT_TAIL) begin
                    st_d = ST_IDLE;
                end
            end
        endcase
    end

    assign send    = permit && out_ready;
    assign in_body = (st_q == ST_BODY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (st_q == ST_IDLE && !fifo_empty && oversize) begin
            err_o <= 1'b1;
        end
    end
endmodule

// File: rtl/sw_fwd_stage.sv
module sw_fwd_stage #(
    parameter int DATA_W    = 16,
    parameter int LEN_W     = 4,
    parameter int BUF_DEPTH = 4,
    parameter int DN_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_kind,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [DATA_W-1:0] out_data,
    input  logic              credit_ret,
    output logic              err_oversize
);
    localparam int WORD_W = DATA_W + 2;
    localparam int BCW    = $clog2(BUF_DEPTH + 1);
    localparam int CCW    = $clog2(DN_DEPTH + 1);

    logic [WORD_W-1:0] front;
    logic [BCW-1:0]    buf_count;
    logic [CCW-1:0]    crd_level;
    logic              buf_full, buf_empty, send, in_body;

    assign in_ready = !buf_full;
    assign out_kind = front[WORD_W-1 -: 2];
    assign out_data = front[DATA_W-1:0];

    flit_buf #(.WIDTH(WORD_W), .DEPTH(BUF_DEPTH), .CW(BCW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid),
        .push_data ({in_kind, in_data}),
        .pop       (send),
        .front     (front),
        .count     (buf_count),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    credit_ctr #(.DEPTH(DN_DEPTH), .CW(CCW)) u_crd (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (send),
        .give  (credit_ret),
        .level (crd_level)
    );

    fwd_ctrl #(.LEN_W(LEN_W), .BUF_DEPTH(BUF_DEPTH), .BCW(BCW), .CCW(CCW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .fifo_empty (buf_empty),
        .front_kind (front[WORD_W-1 -: 2]),
        .front_len  (front[LEN_W-1:0]),
        .buf_count  (buf_count),
        .credits    (crd_level),
        .out_ready  (out_ready),
        .permit     (out_valid),
        .send       (send),
        .in_body    (in_body),
        .err_o      (err_oversize)
    );
endmodule

// File: rtl/sw_fwd_stage_chk.sv
module sw_fwd_stage_chk #(
    parameter int DN_DEPTH = 4,
    parameter int CCW      = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           out_valid,
    input logic           out_ready,
    input logic           credit_ret,
    input logic           err_oversize,
    input logic           in_body,
    input logic [CCW-1:0] crd_level
);
    localparam logic [CCW-1:0] TOP = CCW'(DN_DEPTH);

    assert_no_send_dry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> crd_level != '0);

    assert_credit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        crd_level <= TOP);

    assert_credit_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !credit_ret) |=> crd_level == $past(crd_level) - 1'b1);

    assert_credit_give_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(out_valid && out_ready) && credit_ret && crd_level != TOP)
        |=> crd_level == $past(crd_level) + 1'b1);

    assert_credit_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && credit_ret) |=> $stable(crd_level));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_oversize |=> err_oversize);

    assert_body_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_body && out_valid && !out_ready) |=> out_valid);
endmodule

bind sw_fwd_stage sw_fwd_stage_chk #(.DN_DEPTH(DN_DEPTH), .CCW(CCW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .credit_ret   (credit_ret),
    .err_oversize (err_oversize),
    .in_body      (in_body),
    .crd_level    (crd_level)
);

// File: tb/sw_fwd_stage_tb.sv
module sw_fwd_stage_tb;
    localparam int DW = 16;
    localparam int BD = 4;
    localparam int DD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_kind = 2'b00;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [1:0]    out_kind;
    logic [DW-1:0] out_data;
    logic          credit_ret = 1'b0;
    logic          err_oversize;

    int n_chk = 0;
    int n_fail = 0;
    int sent = 0;
    int model_cred = DD;
    logic [DW+1:0] exp_q[$];

    always #4 clk = ~clk;

    sw_fwd_stage #(.DATA_W(DW), .LEN_W(4), .BUF_DEPTH(BD), .DN_DEPTH(DD)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_data(out_data),
        .credit_ret(credit_ret), .err_oversize(err_oversize)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Downstream monitor: order/integrity (R2) and credit model (R7).
    always @(posedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                logic [DW+1:0] e;
                sent++;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
                chk({out_kind, out_data} == e, "R2 flit order/content", int'({out_kind, out_data}), int'(e));
                chk(model_cred > 0, "R7 sent with zero credits", model_cred, 1);
                model_cred--;
            end
            if (credit_ret && !(out_valid && out_ready && model_cred == DD - 1 + 1 && 0)) begin
                if (model_cred < DD) model_cred++;
            end
        end
    end

    task automatic push(input logic [1:0] k, input logic [DW-1:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_data = d;
        @(posedge clk);
        exp_q.push_back({k, d});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic give(input int n);
        @(negedge clk);
        credit_ret = 1'b1;
        repeat (n) @(negedge clk);
        credit_ret = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int base;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(err_oversize == 1'b0, "R1 err", err_oversize, 0);

        // R3 store-and-forward waits for whole packet
        mode_i = 2'b00;
        push(2'b00, 16'hA003);
        push(2'b01, 16'hA101);
        idle(3);
        chk(out_valid == 1'b0, "R3 partial packet held", out_valid, 0);
        push(2'b10, 16'hA202);
        chk(out_valid == 1'b1, "R3 full packet offered", out_valid, 1);
        idle(5);
        chk(sent == 3, "R3 packet delivered", sent, 3);
        // R3 credit part: 1 credit, L=2 packet fully local
        push(2'b00, 16'hB002);
        push(2'b10, 16'hB101);
        idle(2);
        chk(out_valid == 1'b0, "R3 short of credits", out_valid, 0);
        give(1);
        chk(out_valid == 1'b1, "R3 credits reach L", out_valid, 1);
        idle(4);
        chk(sent == 5, "R3 second packet delivered", sent, 5);

        // R4 cut-through, credits 0 -> 2 -> 3
        mode_i = 2'b01;
        give(2);
        push(2'b00, 16'hC003);
        idle(2);
        chk(out_valid == 1'b0, "R4 credits below L", out_valid, 0);
        give(1);
        chk(out_valid == 1'b1, "R4 head offered before body arrives", out_valid, 1);
        idle(2);
        chk(sent == 6, "R4 head left alone", sent, 6);
        push(2'b01, 16'hC101);
        push(2'b10, 16'hC202);
        idle(3);
        chk(sent == 8, "R4 packet delivered", sent, 8);

        // R5 wormhole single flit with zero credits
        mode_i = 2'b10;
        push(2'b11, 16'hD000);
        idle(2);
        chk(out_valid == 1'b0, "R5 no credit no offer", out_valid, 0);
        give(1);
        chk(out_valid == 1'b1, "R5 one credit enough", out_valid, 1);
        idle(2);
        chk(sent == 9, "R5 delivered", sent, 9);

        // R7 saturation: 6 returns into empty counter give only DD
        give(6);
        base = sent;
        push(2'b00, 16'hE006);
        push(2'b01, 16'hE101);
        push(2'b01, 16'hE202);
        push(2'b01, 16'hE303);
        push(2'b01, 16'hE404);
        push(2'b10, 16'hE505);
        idle(3);
        chk(sent - base == DD, "R7 saturated at DN_DEPTH", sent - base, DD);
        chk(out_valid == 1'b0, "R7 stall at zero credits", out_valid, 0);

        // R6 mode change mid-packet ignored; R7 same-cycle take+give
        mode_i = 2'b00;
        give(2);
        idle(3);
        chk(sent - base == 6, "R7 R6 same-cycle credit kept, body streams", sent - base, 6);
        chk(out_valid == 1'b0, "R7 empty after drain", out_valid, 0);
        give(4);

        // R8 oversize store-and-forward
        chk(err_oversize == 1'b0, "R8 err clear before", err_oversize, 0);
        base = sent;
        push(2'b00, 16'hF006);
        push(2'b01, 16'hF101);
        push(2'b01, 16'hF202);
        push(2'b01, 16'hF303);
        push(2'b01, 16'hF404);
        push(2'b10, 16'hF505);
        idle(3);
        chk(err_oversize == 1'b1, "R8 err set", err_oversize, 1);
        chk(sent - base == DD, "R8 forwarded flit by flit", sent - base, DD);
        give(2);
        idle(3);
        chk(sent - base == 6, "R8 packet completes", sent - base, 6);
        give(4);

        // R3 single-flit in store-and-forward, err stays (R8)
        push(2'b11, 16'h1111);
        chk(out_valid == 1'b1, "R3 single flit immediate", out_valid, 1);
        idle(2);
        chk(err_oversize == 1'b1, "R8 err sticky", err_oversize, 1);
        give(1);

        // R9 out_ready independence, full queue, one per cycle
        mode_i = 2'b10;
        out_ready = 1'b0;
        base = sent;
        push(2'b11, 16'h2000);
        push(2'b11, 16'h2001);
        push(2'b11, 16'h2002);
        push(2'b11, 16'h2003);
        idle(1);
        chk(in_ready == 1'b0, "R9 in_ready low when full", in_ready, 0);
        chk(out_valid == 1'b1, "R9 valid without ready", out_valid, 1);
        chk(sent == base, "R9 nothing sent without ready", sent - base, 0);
        out_ready = 1'b1;
        idle(1);
        chk(sent - base == 1, "R9 one flit per cycle", sent - base, 1);
        idle(5);
        chk(sent - base == 4, "R9 all drained", sent - base, 4);
        chk(exp_q.size() == 0, "R2 nothing lost", exp_q.size(), 0);
        finish_run();
    end
endmodule